// File: doc/BRIEF.md
# DMA Request Cache-Line Splitter

This block takes a single DMA transfer, described by a byte start address, a byte count and a read/write flag with a write payload, and cuts it into a series of memory messages. No message crosses a cache-line boundary. Each message gives the full physical byte address, the line-aligned address, the byte offset inside the line, the byte count and the direction. For writes it also gives a line-wide data word with the payload bytes placed at their in-line positions. Only one message is in flight at a time. The next one is offered only after the memory side has answered the previous one.

On reads, each answer carries a whole line. The block copies the useful bytes of that line into a requester-side buffer at the right position. Only the first chunk of an unaligned transfer is taken from a non-zero position within the line. When every byte has been answered, the block pulses `done` and returns to idle. A transfer of zero bytes completes without sending any message. A request that arrives while a transfer is running is refused and flagged.

The controller has four states. `ST_IDLE` waits for a request. `ST_ISSUE` offers a message. `ST_WAIT` waits for its answer. `ST_FINISH` pulses completion. The transitions are:
- `ST_IDLE` goes to `ST_ISSUE` when it accepts a request with a non-zero length, or to `ST_FINISH` when the length is zero.
- `ST_ISSUE` goes to `ST_WAIT` on the message handshake.
- `ST_WAIT` goes to `ST_ISSUE` on an answer while bytes remain, or to `ST_FINISH` on the answer for the last chunk.
- `ST_FINISH` always goes to `ST_IDLE`.

Top module: `dma_line_splitter`

## Requirements
- R1: After reset `busy`, `msg_valid`, `done` and `req_err` are 0. A request seen with `req_valid` while idle is accepted on that edge, and `busy` is 1 from the next cycle. For a non-zero length, `msg_valid` is also 1 from the next cycle.
- R2: A `req_valid` seen while `busy` is 1 is ignored, and `req_err` is 1 in the following cycle. The running transfer produces exactly the messages and read data it would have produced without it.
- R3: `msg_addr` equals the start address plus the bytes already completed. `msg_offset` equals `msg_addr` ANDed with `LINE_BYTES-1`. `msg_line_addr` equals `msg_addr` with its low log2(`LINE_BYTES`) bits cleared.
- R4: For the first message, `msg_len` equals the request length when offset plus length is at most `LINE_BYTES`. Otherwise it equals `LINE_BYTES` minus the offset.
- R5: Every later message has offset 0. Its `msg_len` equals the remaining byte count when that is below `LINE_BYTES`, and `LINE_BYTES` otherwise.
- R6: For a write, byte k of `msg_data` (bits 8k+7:8k) holds payload byte (completed + k − offset) when offset ≤ k < offset + `msg_len`, and 0 otherwise. Payload byte i is `req_wdata` bits 8i+7:8i, captured at acceptance.
- R7: `msg_valid` stays 1, with all message fields unchanged, until `msg_ready`. After a handshake, `msg_valid` stays 0 until an answer has been received.
- R8: `rd_buf` is cleared to zero when a request is accepted. On a read answer, line bytes offset … offset+n−1 are written into `rd_buf` bytes completed … completed+n−1, where n is bytes issued minus bytes completed. The offset is the start offset for the first chunk and 0 after that.
- R9: The cycle after the answer to the last chunk, `done` is 1 for exactly one cycle while `busy` is still 1. In the cycle after that, `busy` is 0.
- R10: A zero-length request sends no message. `done` is 1 in the cycle after acceptance.
- R11: `rsp_valid` outside the answer-wait state has no effect on `rd_buf`, `busy` or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_W | Byte count |
| req_wdata | input | 8·2^LEN_W | Write payload, byte i at bits 8i+7:8i |
| busy | output | 1 | A transfer is in progress |
| req_err | output | 1 | Request refused because busy |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Memory side takes the message |
| msg_write | output | 1 | Message direction |
| msg_addr | output | ADDR_W | Physical byte address of the chunk |
| msg_line_addr | output | ADDR_W | Line-aligned address |
| msg_offset | output | log2(LINE_BYTES) | Byte offset within the line |
| msg_len | output | log2(LINE_BYTES)+1 | Byte count of the chunk |
| msg_data | output | 8·LINE_BYTES | Write data placed in the line |
| rsp_valid | input | 1 | Answer strobe (read data or write acknowledge) |
| rsp_data | input | 8·LINE_BYTES | Returned line for reads |
| done | output | 1 | One-cycle completion pulse |
| rd_buf | output | 8·2^LEN_W | Gathered read data |

## Verification
The bench aims at unaligned starts, chunks that end exactly on a line boundary, full-line middle chunks, short tails, zero-length transfers and the longest allowed transfer.
- If the first-chunk length were not clipped, a message would spill past the line and the next address would be misaligned.
- If write bytes were placed at byte zero instead of at the offset, the line data would come out shifted.
- If every read answer were taken from the start offset, all chunks after the first would gather the wrong bytes.

Further stimulus sends a request in the middle of a transfer and a stray answer while idle. A design that accepted either one would corrupt the running transfer's messages or the read buffer, or would raise a spurious completion.

// File: rtl/dls_pkg.sv
package dls_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } dls_state_e;

endpackage

// File: rtl/dls_chunk_calc.sv
// Works out the fields of the current chunk from the transfer start,
// the byte count already completed and the total length.
module dls_chunk_calc #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 6,
    parameter int LINE_BYTES = 16
) (
    input  logic [ADDR_W-1:0]                 start_addr,
    input  logic [LEN_W-1:0]                  done_cnt,
    input  logic [LEN_W-1:0]                  total_len,
    output logic [ADDR_W-1:0]                 phys_addr,
    output logic [ADDR_W-1:0]                 line_addr,
    output logic [$clog2(LINE_BYTES)-1:0]     offset,
    output logic [$clog2(LINE_BYTES):0]       chunk_len
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int CLEN_W = OFF_W + 1;
    localparam int SUM_W  = LEN_W + 1;
    localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'((1 << OFF_W) - 1);
    localparam logic [SUM_W-1:0]  LINE_SUM  = SUM_W'(LINE_BYTES);
    localparam logic [LEN_W-1:0]  LINE_LEN  = LEN_W'(LINE_BYTES);
    localparam logic [CLEN_W-1:0] LINE_CLEN = CLEN_W'(LINE_BYTES);

    logic                  first_chunk;
    logic [LEN_W-1:0]      remaining;
    logic [SUM_W-1:0]      end_pos;
    logic [OFF_W-1:0]      start_off;

    assign first_chunk = (done_cnt == '0);
    assign phys_addr   = start_addr + ADDR_W'(done_cnt);
    assign line_addr   = phys_addr & ~OFF_MASK;
    assign start_off   = OFF_W'(start_addr & OFF_MASK);
    assign remaining   = total_len - done_cnt;
    assign end_pos     = SUM_W'(start_off) + {1'b0, total_len};

    always_comb begin
        if (first_chunk) begin
            offset = start_off;
            if (end_pos <= LINE_SUM) begin
                chunk_len = CLEN_W'(total_len);
            end else begin
                chunk_len = LINE_CLEN - CLEN_W'(start_off);
            end
        end else begin
            offset = '0;
            if (remaining < LINE_LEN) begin
                chunk_len = CLEN_W'(remaining);
            end else begin
                chunk_len = LINE_CLEN;
            end
        end
    end

endmodule

// File: rtl/dls_wr_pack.sv
// Places the payload bytes of one chunk at their in-line positions.
module dls_wr_pack #(
    parameter int LEN_W      = 6,
    parameter int LINE_BYTES = 16
) (
    input  logic [8*(1<<LEN_W)-1:0]          payload,
    input  logic [LEN_W-1:0]                 base,
    input  logic [$clog2(LINE_BYTES)-1:0]    offset,
    input  logic [$clog2(LINE_BYTES):0]      chunk_len,
    output logic [8*LINE_BYTES-1:0]          line
);
    localparam int BUF_BYTES = 1 << LEN_W;

    for (genvar k = 0; k < LINE_BYTES; k++) begin : g_byte
        always_comb begin
            int rel;
            rel = int'(base) + k - int'(offset);
            line[8*k +: 8] = 8'h00;
            if ((k >= int'(offset)) && (k < int'(offset) + int'(chunk_len))
                && (rel >= 0) && (rel < BUF_BYTES)) begin
                line[8*k +: 8] = payload[8*rel +: 8];
            end
        end
    end

endmodule

// File: rtl/dls_rd_gather.sv
// Copies the useful bytes of a returned line into the requester buffer.
module dls_rd_gather #(
    parameter int LEN_W      = 6,
    parameter int LINE_BYTES = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear,
    input  logic                             wr_en,
    input  logic [LEN_W-1:0]                 base,
    input  logic [$clog2(LINE_BYTES)-1:0]    offset,
    input  logic [$clog2(LINE_BYTES):0]      copy_len,
    input  logic [8*LINE_BYTES-1:0]          line,
    output logic [8*(1<<LEN_W)-1:0]          buf_q
);
    localparam int BUF_BYTES = 1 << LEN_W;

    for (genvar i = 0; i < BUF_BYTES; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                buf_q[8*i +: 8] <= 8'h00;
            end else if (clear) begin
                buf_q[8*i +: 8] <= 8'h00;
            end else if (wr_en && (i >= int'(base))
                         && (i < int'(base) + int'(copy_len))
                         && (int'(offset) + i - int'(base) < LINE_BYTES)) begin
                buf_q[8*i +: 8] <= line[8*(int'(offset) + i - int'(base)) +: 8];
            end
        end
    end

endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 6,
    parameter int LINE_BYTES = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic                               req_write,
    input  logic [ADDR_W-1:0]                  req_addr,
    input  logic [LEN_W-1:0]                   req_len,
    input  logic [8*(1<<LEN_W)-1:0]            req_wdata,
    output logic                               busy,
    output logic                               req_err,
    output logic                               msg_valid,
    input  logic                               msg_ready,
    output logic                               msg_write,
    output logic [ADDR_W-1:0]                  msg_addr,
    output logic [ADDR_W-1:0]                  msg_line_addr,
    output logic [$clog2(LINE_BYTES)-1:0]      msg_offset,
    output logic [$clog2(LINE_BYTES):0]        msg_len,
    output logic [8*LINE_BYTES-1:0]            msg_data,
    input  logic                               rsp_valid,
    input  logic [8*LINE_BYTES-1:0]            rsp_data,
    output logic                               done,
    output logic [8*(1<<LEN_W)-1:0]            rd_buf
);
    import dls_pkg::*;

    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int CLEN_W   = OFF_W + 1;
    localparam int BUF_BITS = 8 * (1 << LEN_W);

    dls_state_e            state_q, state_d;
    logic [ADDR_W-1:0]     start_q;
    logic [LEN_W-1:0]      total_q;
    logic [LEN_W-1:0]      completed_q;
    logic [LEN_W-1:0]      issued_q;
    logic                  write_q;
    logic [BUF_BITS-1:0]   payload_q;
    logic                  err_q;

    logic                  accept;
    logic                  gather_en;
    logic [CLEN_W-1:0]     outstanding;
    logic [ADDR_W-1:0]     cur_addr;
    logic [ADDR_W-1:0]     cur_line;
    logic [OFF_W-1:0]      cur_off;
    logic [CLEN_W-1:0]     cur_len;

    dls_chunk_calc #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .LINE_BYTES(LINE_BYTES)
    ) u_calc (
        .start_addr(start_q),
        .done_cnt  (completed_q),
        .total_len (total_q),
        .phys_addr (cur_addr),
        .line_addr (cur_line),
        .offset    (cur_off),
        .chunk_len (cur_len)
    );

    dls_wr_pack #(
        .LEN_W     (LEN_W),
        .LINE_BYTES(LINE_BYTES)
    ) u_pack (
        .payload  (payload_q),
        .base     (completed_q),
        .offset   (cur_off),
        .chunk_len(cur_len),
        .line     (msg_data)
    );

    dls_rd_gather #(
        .LEN_W     (LEN_W),
        .LINE_BYTES(LINE_BYTES)
    ) u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .wr_en   (gather_en),
        .base    (completed_q),
        .offset  (cur_off),
        .copy_len(outstanding),
        .line    (rsp_data),
        .buf_q   (rd_buf)
    );

    assign accept      = (state_q == ST_IDLE) && req_valid;
    assign gather_en   = (state_q == ST_WAIT) && rsp_valid && !write_q;
    assign outstanding = CLEN_W'(issued_q - completed_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (req_len == '0) ? ST_FINISH : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (msg_ready) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    state_d = (issued_q == total_q) ? ST_FINISH : ST_ISSUE;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        msg_valid     = (state_q == ST_ISSUE);
        done          = (state_q == ST_FINISH);
        req_err       = err_q;
        msg_write     = write_q;
        msg_addr      = cur_addr;
        msg_line_addr = cur_line;
        msg_offset    = cur_off;
        msg_len       = cur_len;
    end

    // transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q     <= '0;
            total_q     <= '0;
            completed_q <= '0;
            issued_q    <= '0;
            write_q     <= 1'b0;
            payload_q   <= '0;
            err_q       <= 1'b0;
        end else begin
            err_q <= req_valid && (state_q != ST_IDLE);
            if (accept) begin
                start_q     <= req_addr;
                total_q     <= req_len;
                write_q     <= req_write;
                payload_q   <= req_wdata;
                completed_q <= '0;
                issued_q    <= '0;
            end
            if ((state_q == ST_ISSUE) && msg_ready) begin
                issued_q <= completed_q + LEN_W'(cur_len);
            end
            if ((state_q == ST_WAIT) && rsp_valid) begin
                completed_q <= issued_q;
            end
        end
    end

endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic                               busy,
    input  logic                               req_err,
    input  logic                               msg_valid,
    input  logic                               msg_ready,
    input  logic [ADDR_W-1:0]                  msg_addr,
    input  logic [ADDR_W-1:0]                  msg_line_addr,
    input  logic [$clog2(LINE_BYTES)-1:0]      msg_offset,
    input  logic [$clog2(LINE_BYTES):0]        msg_len,
    input  logic                               done
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SW    = OFF_W + 2;

    p_no_msg_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !msg_valid)
        else $error("R1: message offered while idle");

    p_err_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> req_err)
        else $error("R2: refused request not flagged");

    p_addr_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ((msg_line_addr[OFF_W-1:0] == '0)
                       && (msg_line_addr + ADDR_W'(msg_offset) == msg_addr)))
        else $error("R3: line address and offset disagree with address");

    p_len_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ((msg_len != '0)
                       && (SW'(msg_offset) + SW'(msg_len) <= SW'(LINE_BYTES))))
        else $error("R4: chunk crosses the line boundary");

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr)
                                       && $stable(msg_len)))
        else $error("R7: message dropped or changed before handshake");

    p_one_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid)
        else $error("R7: second message without answer");

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy ##1 (!done && !busy))
        else $error("R9: completion pulse malformed");

endmodule

bind dma_line_splitter dls_checker #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES)
) u_dls_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .busy         (busy),
    .req_err      (req_err),
    .msg_valid    (msg_valid),
    .msg_ready    (msg_ready),
    .msg_addr     (msg_addr),
    .msg_line_addr(msg_line_addr),
    .msg_offset   (msg_offset),
    .msg_len      (msg_len),
    .done         (done)
);

// File: tb/test_dma_line_splitter.sv
`timescale 1ns/1ps
module test_dma_line_splitter;
    localparam int AW = 32;
    localparam int LW = 6;
    localparam int LB = 16;
    localparam int OW = 4;
    localparam int BB = 1 << LW;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic [AW-1:0]      req_addr = '0;
    logic [LW-1:0]      req_len = '0;
    logic [8*BB-1:0]    req_wdata = '0;
    logic               busy, req_err, msg_valid, msg_write, done;
    logic               msg_ready;
    logic [AW-1:0]      msg_addr, msg_line_addr;
    logic [OW-1:0]      msg_offset;
    logic [OW:0]        msg_len;
    logic [8*LB-1:0]    msg_data;
    logic               rsp_valid;
    logic [8*LB-1:0]    rsp_data;
    logic [8*BB-1:0]    rd_buf;

    int n_checks = 0;
    int n_fails  = 0;
    bit stray_req = 1'b0;

    typedef struct {
        logic [AW-1:0]   addr;
        logic [OW-1:0]   off;
        logic [OW:0]     len;
        logic            wr;
        logic            first;
        logic [8*LB-1:0] data;
    } exp_msg_t;
    exp_msg_t exp_q[$];

    always #5 clk = ~clk;

    dma_line_splitter #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB)) i_dma_line_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .busy(busy), .req_err(req_err), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_write(msg_write), .msg_addr(msg_addr), .msg_line_addr(msg_line_addr),
        .msg_offset(msg_offset), .msg_len(msg_len), .msg_data(msg_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .rd_buf(rd_buf)
    );

    function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
        return a[7:0] * 8'd7 + 8'd3 + a[15:8];
    endfunction

    function automatic logic [8*LB-1:0] mem_line(logic [AW-1:0] la);
        logic [8*LB-1:0] l;
        for (int k = 0; k < LB; k++) l[8*k +: 8] = mem_byte(la + AW'(k));
        return l;
    endfunction

    task automatic check(bit ok, string req, string what, logic [8*BB-1:0] act,
                         logic [8*BB-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // scoreboard driver side: expected message list
    task automatic plan_msgs(logic [AW-1:0] addr, int len, bit wr, logic [8*BB-1:0] pay);
        int dn = 0;
        while (dn < len) begin
            exp_msg_t m;
            int off, n;
            m.addr = addr + AW'(dn);
            off = (dn == 0) ? int'(m.addr % LB) : 0;
            if (dn == 0) n = (off + len <= LB) ? len : LB - off;
            else         n = (len - dn < LB) ? len - dn : LB;
            m.off = OW'(off);
            m.len = (OW+1)'(n);
            m.wr = wr;
            m.first = (dn == 0);
            m.data = '0;
            if (wr) for (int k = 0; k < n; k++) m.data[8*(off+k) +: 8] = pay[8*(dn+k) +: 8];
            exp_q.push_back(m);
            dn += n;
        end
    endtask

    // monitor and memory responder
    initial begin
        int rcnt = 0;
        int due = 0;
        logic [AW-1:0] last_line = '0;
        msg_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (due > 0) begin
                check(!msg_valid, "R7", "msg_valid while answer pending", 512'(msg_valid), 0);
                due--;
                if (due == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = mem_line(last_line);
                end
            end else if (stray_req) begin
                stray_req = 1'b0;
                rsp_valid = 1'b1;
                rsp_data  = {LB{8'hA5}};
            end
            rcnt++;
            msg_ready = (rcnt % 3 != 0);
            if (msg_valid && msg_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected extra message", 512'(msg_addr), 0);
                end else begin
                    exp_msg_t e;
                    e = exp_q.pop_front();
                    check(msg_addr == e.addr, "R3", "msg_addr", 512'(msg_addr), 512'(e.addr));
                    check(msg_offset == e.off, "R3", "msg_offset", 512'(msg_offset), 512'(e.off));
                    check(msg_line_addr == (e.addr & ~AW'(LB-1)), "R3", "msg_line_addr",
                          512'(msg_line_addr), 512'(e.addr & ~AW'(LB-1)));
                    check(msg_len == e.len, e.first ? "R4" : "R5", "msg_len",
                          512'(msg_len), 512'(e.len));
                    check(msg_write == e.wr, "R1", "msg_write", 512'(msg_write), 512'(e.wr));
                    if (e.wr) check(msg_data == e.data, "R6", "msg_data",
                                    512'(msg_data), 512'(e.data));
                end
                last_line = msg_line_addr;
                due = 2;
            end
        end
    end

    // watchdog
    initial begin
        #(10 * 100000);
        check(1'b0, "R9", "watchdog expired", 0, 1);
        finish_up();
    end

    task automatic run_xfer(logic [AW-1:0] addr, int len, bit wr, int seed, bit inject);
        logic [8*BB-1:0] pay;
        logic [8*BB-1:0] exp_buf;
        bit seen = 1'b0;
        for (int i = 0; i < BB; i++) pay[8*i +: 8] = 8'(i * 5 + seed);
        plan_msgs(addr, len, wr, pay);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_len = LW'(len); req_wdata = pay;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R1", "busy after accept", 512'(busy), 1);
        if (inject) begin
            req_valid = 1'b1; req_write = ~wr; req_addr = addr + 32'h100;
            req_len = 6'd7; req_wdata = ~pay;
            @(negedge clk);
            req_valid = 1'b0;
            check(req_err == 1'b1, "R2", "req_err after busy request", 512'(req_err), 1);
            if (done) seen = 1'b1;
        end
        for (int c = 0; c < 600 && !seen; c++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        check(seen, "R9", "done pulse", 512'(seen), 1);
        check(busy == 1'b1, "R9", "busy during done", 512'(busy), 1);
        check(exp_q.size() == 0, inject ? "R2" : "R9", "messages remaining",
              512'(exp_q.size()), 0);
        exp_q.delete();
        if (!wr) begin
            exp_buf = '0;
            for (int i = 0; i < len; i++) exp_buf[8*i +: 8] = mem_byte(addr + AW'(i));
            check(rd_buf == exp_buf, "R8", "gathered read data", rd_buf, exp_buf);
        end
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R9", "idle after done",
              512'({busy, done}), 0);
    endtask

    initial begin
        logic [8*BB-1:0] snap;
        bit any_done;
        repeat (3) @(negedge clk);
        check({busy, msg_valid, done, req_err} == 4'b0, "R1", "reset outputs",
              512'({busy, msg_valid, done, req_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_xfer(32'h0000_1000, 32, 1'b1, 11, 1'b0);   // aligned write, two full lines
        run_xfer(32'h0000_2005, 40, 1'b1, 3,  1'b0);   // unaligned write with tail
        run_xfer(32'h0000_3003, 13, 1'b1, 77, 1'b0);   // ends exactly on line edge
        run_xfer(32'h0000_400A, 30, 1'b0, 0,  1'b0);   // unaligned read
        run_xfer(32'h0000_5002, 5,  1'b0, 0,  1'b0);   // read inside one line
        run_xfer(32'h0000_6001, 63, 1'b0, 0,  1'b0);   // longest read
        run_xfer(32'h0000_700F, 40, 1'b0, 0,  1'b1);   // busy request injected
        run_xfer(32'h0000_8004, 20, 1'b1, 9,  1'b1);   // busy request on write

        // zero length
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_9007; req_len = '0;
        @(negedge clk);
        req_valid = 1'b0;
        check(done == 1'b1 && msg_valid == 1'b0, "R10", "zero length completes at once",
              512'({done, msg_valid}), 512'(2'b10));
        @(negedge clk);
        check(busy == 1'b0, "R10", "idle after zero length", 512'(busy), 0);
        check(rd_buf == '0, "R8", "buffer cleared on accept", rd_buf, 0);

        // stray answer while idle
        run_xfer(32'h0000_A003, 9, 1'b0, 0, 1'b0);
        snap = rd_buf;
        stray_req = 1'b1;
        any_done = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (done || busy) any_done = 1'b1;
        end
        check(!any_done, "R11", "stray answer caused activity", 512'(any_done), 0);
        check(rd_buf == snap, "R11", "stray answer touched buffer", rd_buf, snap);

        finish_up();
    end

endmodule